// File: doc/BRIEF.md
# Calibration Pulse and Trigger Sequencer

This block takes a decoded command made of two 8-bit selector fields and a payload of ten 16-bit pattern words. It acts only when both selectors carry the calibration-with-trigger code. When it accepts such a command, it fires a one-cycle calibration pulse. It then walks the payload one bit per clock and fires a single trigger strobe when the bit group 1-1-0 first appears.

The delay between the calibration pulse and the trigger is not a binary count. It is the number of zero bits placed ahead of the 1-1-0 marker. The marker may cross the boundary between two words. Bits that follow the marker are never looked at. If the payload holds no marker, the block reports an error and issues no trigger. A command that arrives while a sequence is running is dropped and leaves a sticky overrun flag.

Top module: `cal_trig_seq`

## Requirements
- R1: A command is accepted only when `cmd_valid_i` is high while the block is idle, with `sel_a_i` equal to 0x0C and `sel_b_i` equal to 0x30. Any other command leaves `busy_o` and `cal_pulse_o` low.
- R2: `cal_pulse_o` is high for exactly one cycle, in the cycle after the accepting clock edge. `busy_o` rises in that same cycle.
- R3: Payload word w sits in `pattern_i[16*w+15:16*w]`. Bits are consumed from word 0 upward, and from bit 15 down to bit 0 within each word.
- R4: When N zero bits precede the first 1-1-0 group, `trig_o` rises exactly N+4 cycles after `cal_pulse_o` rises and stays high for one cycle. For example, seven zero words followed by 0x6000 gives N=113, and six zero words followed by 0x0C00 gives N=100.
- R5: A marker that straddles two words triggers normally. For example, word 2 equal to 0x0001 and word 3 equal to 0x8000 gives N=47.
- R6: Bits after the completing 0 of the marker have no effect on the trigger time. This includes all later words.
- R7: `busy_o` falls in the cycle after `trig_o`. At that point `done_o` is high and `err_o` is low. Both flags clear on the next accepted command.
- R8: If all 160 bits are consumed with no 1-1-0 group, `trig_o` never rises. `err_o` and the fall of `busy_o` both occur 161 cycles after `cal_pulse_o` rises. A marker whose final 0 is bit 0 of word 9 still triggers.
- R9: Raising `cmd_valid_i` while `busy_o` is high does not change the running sequence and sets `overrun_o`. `overrun_o` stays set until reset.
- R10: While `rst_ni` is low, every output is low, and this takes effect without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command present for one cycle |
| sel_a_i | input | 8 | First selector field |
| sel_b_i | input | 8 | Second selector field |
| pattern_i | input | 160 | Ten packed 16-bit pattern words, word 0 in the low bits |
| busy_o | output | 1 | Sequence in progress |
| cal_pulse_o | output | 1 | One-cycle calibration pulse |
| trig_o | output | 1 | One-cycle trigger strobe |
| done_o | output | 1 | Last sequence ended with a trigger |
| err_o | output | 1 | Last sequence ended with no marker |
| overrun_o | output | 1 | Sticky: command seen while busy |

## Verification
The assertions assume that `cmd_valid_i` marks a single command as a pulse. They also assume that the selectors and the payload are stable on the edge where that pulse is sampled, because the payload is captured only on that edge. The bench holds each command for exactly one cycle and changes the fields only on falling edges. Its one deliberate violation, a command raised during a running sequence, is there to exercise the overrun path. The bit-counter property relies on the controller never shifting past the last payload bit. The stimulus reaches that limit on purpose with the all-zero payload and with markers placed at the very end of word 9.

// File: rtl/cal_seq_pkg.sv
package cal_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CAL   = 2'd1,
    ST_SHIFT = 2'd2,
    ST_TRIG  = 2'd3
  } seq_state_e;
endpackage

// File: rtl/cal_cmd_decode.sv
module cal_cmd_decode #(
  parameter int unsigned       SEL_W   = 8,
  parameter logic [SEL_W-1:0]  MATCH_A = 8'h0C,
  parameter logic [SEL_W-1:0]  MATCH_B = 8'h30
) (
  input  logic [SEL_W-1:0] sel_a_i,
  input  logic [SEL_W-1:0] sel_b_i,
  output logic             hit_o
);
  assign hit_o = (sel_a_i == MATCH_A) && (sel_b_i == MATCH_B);
endmodule

// File: rtl/cal_pattern_shifter.sv
module cal_pattern_shifter #(
  parameter int unsigned WORD_W    = 16,
  parameter int unsigned NUM_WORDS = 10,
  localparam int unsigned PAT_W    = WORD_W * NUM_WORDS,
  localparam int unsigned IDX_W    = $clog2(PAT_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             shift_i,
  input  logic [PAT_W-1:0] pattern_i,
  output logic             term_o,
  output logic             last_o
);
  logic [PAT_W-1:0] ordered;
  logic [PAT_W-1:0] shreg_q;
  logic [IDX_W-1:0] cnt_q;
  logic [1:0]       hist_q;

  // consumption order: word 0 first, msb first; bit k lands at ordered[PAT_W-1-k]
  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    for (genvar b = 0; b < WORD_W; b++) begin : g_bit
      assign ordered[PAT_W-1-(w*WORD_W + (WORD_W-1-b))] = pattern_i[w*WORD_W + b];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shreg_q <= '0;
      cnt_q   <= '0;
      hist_q  <= '0;
    end else if (load_i) begin
      shreg_q <= ordered;
      cnt_q   <= '0;
      hist_q  <= '0;
    end else if (shift_i) begin
      shreg_q <= shreg_q << 1;
      cnt_q   <= cnt_q + 1'b1;
      hist_q  <= {hist_q[0], shreg_q[PAT_W-1]};
    end
  end

  assign term_o = (hist_q == 2'b11) && !shreg_q[PAT_W-1];
  assign last_o = (cnt_q == IDX_W'(PAT_W-1));

  // R8
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_i |-> (cnt_q <= IDX_W'(PAT_W-1)));
endmodule

// File: rtl/cal_seq_ctrl.sv
module cal_seq_ctrl
  import cal_seq_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cmd_valid_i,
  input  logic hit_i,
  input  logic term_i,
  input  logic last_i,
  output logic load_o,
  output logic shift_o,
  output logic busy_o,
  output logic cal_pulse_o,
  output logic trig_o,
  output logic done_o,
  output logic err_o,
  output logic overrun_o
);
  seq_state_e state_q, state_d;
  logic done_q, err_q, ovr_q;
  logic accept;

  assign accept  = (state_q == ST_IDLE) && cmd_valid_i && hit_i;
  assign load_o  = accept;
  assign shift_o = (state_q == ST_SHIFT);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (accept) state_d = ST_CAL;
      ST_CAL:   state_d = ST_SHIFT;
      ST_SHIFT: begin
        if (term_i)      state_d = ST_TRIG;
        else if (last_i) state_d = ST_IDLE;
      end
      ST_TRIG:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      ovr_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        done_q <= 1'b0;
        err_q  <= 1'b0;
      end else if (state_q == ST_SHIFT) begin
        if (term_i)      done_q <= 1'b1;
        else if (last_i) err_q  <= 1'b1;
      end
      if (cmd_valid_i && (state_q != ST_IDLE)) ovr_q <= 1'b1;
    end
  end

  assign busy_o      = (state_q != ST_IDLE);
  assign cal_pulse_o = (state_q == ST_CAL);
  assign trig_o      = (state_q == ST_TRIG);
  assign done_o      = done_q;
  assign err_o       = err_q;
  assign overrun_o   = ovr_q;

  // R2
  cal_one_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cal_pulse_o |=> !cal_pulse_o);
  // R2
  busy_with_cal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> cal_pulse_o);
  // R4
  trig_one_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o |=> !trig_o);
  // R7
  busy_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o |=> (!busy_o && done_o));
  // R8
  err_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !done_o);
  // R9
  overrun_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_o |=> overrun_o);
  // R9
  busy_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && cmd_valid_i) |=> (overrun_o && !cal_pulse_o));
endmodule

// File: rtl/cal_trig_seq.sv
module cal_trig_seq #(
  parameter int unsigned WORD_W    = 16,
  parameter int unsigned NUM_WORDS = 10,
  parameter int unsigned SEL_W     = 8,
  parameter logic [SEL_W-1:0] CMD_A = 8'h0C,
  parameter logic [SEL_W-1:0] CMD_B = 8'h30,
  localparam int unsigned PAT_W    = WORD_W * NUM_WORDS
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_valid_i,
  input  logic [SEL_W-1:0] sel_a_i,
  input  logic [SEL_W-1:0] sel_b_i,
  input  logic [PAT_W-1:0] pattern_i,
  output logic             busy_o,
  output logic             cal_pulse_o,
  output logic             trig_o,
  output logic             done_o,
  output logic             err_o,
  output logic             overrun_o
);
  logic hit, load, shift, term, last;

  cal_cmd_decode #(.SEL_W(SEL_W), .MATCH_A(CMD_A), .MATCH_B(CMD_B)) u_dec (
    .sel_a_i (sel_a_i),
    .sel_b_i (sel_b_i),
    .hit_o   (hit)
  );

  cal_pattern_shifter #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS)) u_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .shift_i   (shift),
    .pattern_i (pattern_i),
    .term_o    (term),
    .last_o    (last)
  );

  cal_seq_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_valid_i (cmd_valid_i),
    .hit_i       (hit),
    .term_i      (term),
    .last_i      (last),
    .load_o      (load),
    .shift_o     (shift),
    .busy_o      (busy_o),
    .cal_pulse_o (cal_pulse_o),
    .trig_o      (trig_o),
    .done_o      (done_o),
    .err_o       (err_o),
    .overrun_o   (overrun_o)
  );

  // R1
  accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && !busy_o && sel_a_i == CMD_A && sel_b_i == CMD_B) |=> cal_pulse_o);
  // R1
  reject_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cmd_valid_i && !busy_o && sel_a_i == CMD_A && sel_b_i == CMD_B) |=> !cal_pulse_o);
endmodule

// File: tb/tb_cal_trig_seq.sv
`timescale 1ns/1ps
module tb_cal_trig_seq;
  typedef struct packed {
    logic [7:0]   a;
    logic [7:0]   b;
    logic [159:0] pat;
    logic         acc;
    logic         trg;
    int unsigned  lat;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{8'h0C, 8'h30, 160'h0003,                       1'b1, 1'b1, 18},  // R3 N=14
    '{8'h0C, 8'h30, {32'h0, 16'h6000, 112'h0},      1'b1, 1'b1, 117}, // R4 N=113
    '{8'h0C, 8'h30, {48'h0, 16'h0C00, 96'h0},       1'b1, 1'b1, 104}, // R4 N=100
    '{8'h0C, 8'h30, {96'h0, 16'h8000, 16'h0001, 32'h0}, 1'b1, 1'b1, 51}, // R5 N=47
    '{8'h0C, 8'h30, {{9{16'hFFFF}}, 16'hC000},      1'b1, 1'b1, 4},   // R6 N=0
    '{8'h0C, 8'h31, 160'h0003,                       1'b0, 1'b0, 0},   // R1
    '{8'h0D, 8'h30, 160'h0003,                       1'b0, 1'b0, 0},   // R1
    '{8'h0C, 8'h30, 160'h0,                          1'b1, 1'b0, 161}, // R8
    '{8'h0C, 8'h30, {16'h0003, 144'h0},             1'b1, 1'b0, 161}, // R8
    '{8'h0C, 8'h30, {16'h0006, 144'h0},             1'b1, 1'b1, 161}  // R8 N=157
  };

  logic clk = 1'b0, rst_ni = 1'b0, cmd_valid_i = 1'b0;
  logic [7:0] sel_a_i = '0, sel_b_i = '0;
  logic [159:0] pattern_i = '0;
  logic busy_o, cal_pulse_o, trig_o, done_o, err_o, overrun_o;
  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  cal_trig_seq dut (
    .clk_i(clk), .rst_ni(rst_ni), .cmd_valid_i(cmd_valid_i),
    .sel_a_i(sel_a_i), .sel_b_i(sel_b_i), .pattern_i(pattern_i),
    .busy_o(busy_o), .cal_pulse_o(cal_pulse_o), .trig_o(trig_o),
    .done_o(done_o), .err_o(err_o), .overrun_o(overrun_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // intr_at >= 0 raises a second command k cycles into the run
  task automatic run(input vec_t v, input int intr_at);
    int k, trig_k, trig_n, err_k, cal_n;
    @(negedge clk);
    sel_a_i = v.a; sel_b_i = v.b; pattern_i = v.pat; cmd_valid_i = 1'b1;
    @(negedge clk);
    cmd_valid_i = 1'b0;
    if (!v.acc) begin
      cal_n = 0;
      for (int i = 0; i < 4; i++) begin
        cal_n += int'(cal_pulse_o) + int'(busy_o);
        @(negedge clk);
      end
      chk(cal_n == 0, "R1 reject", cal_n, 0);
      return;
    end
    chk(cal_pulse_o && busy_o, "R2 cal+busy", int'({cal_pulse_o, busy_o}), 3);
    chk(!err_o && !done_o && !trig_o, "R7 flags cleared", int'({err_o, done_o, trig_o}), 0);
    k = 0; trig_k = -1; trig_n = 0; err_k = -1; cal_n = 0;
    while (busy_o && k < 400) begin
      @(negedge clk);
      k++;
      if (k == intr_at) begin
        sel_a_i = 8'h0C; sel_b_i = 8'h30; pattern_i = 160'hC000; cmd_valid_i = 1'b1;
      end else if (k == intr_at + 1) cmd_valid_i = 1'b0;
      if (trig_o) begin trig_n++; if (trig_k < 0) trig_k = k; end
      if (err_o && err_k < 0) err_k = k;
      if (cal_pulse_o) cal_n++;
    end
    chk(cal_n == 0, "R2 single cal", cal_n, 0);
    if (v.trg) begin
      chk(trig_k == int'(v.lat), "R4 trig latency", trig_k, int'(v.lat));
      chk(trig_n == 1, "R4 trig width", trig_n, 1);
      chk(k == int'(v.lat) + 1, "R7 busy drop", k, int'(v.lat) + 1);
      chk(done_o && !err_o, "R7 done", int'({done_o, err_o}), 2);
    end else begin
      chk(trig_n == 0, "R8 no trig", trig_n, 0);
      chk(err_k == int'(v.lat), "R8 err time", err_k, int'(v.lat));
      chk(k == int'(v.lat), "R8 busy drop", k, int'(v.lat));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk({busy_o, cal_pulse_o, trig_o, done_o, err_o, overrun_o} == 6'b0, "R10 reset",
        int'({busy_o, cal_pulse_o, trig_o, done_o, err_o, overrun_o}), 0);
    rst_ni = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) run(VECS[i], -1);

    // R9 overrun: second command mid-run is dropped
    chk(!overrun_o, "R9 no overrun yet", int'(overrun_o), 0);
    run(VECS[1], 10);
    chk(overrun_o, "R9 overrun set", int'(overrun_o), 1);
    run(VECS[0], -1);
    chk(overrun_o, "R9 overrun sticky", int'(overrun_o), 1);

    // R10 asynchronous reset mid-sequence
    @(negedge clk);
    sel_a_i = 8'h0C; sel_b_i = 8'h30; pattern_i = VECS[1].pat; cmd_valid_i = 1'b1;
    @(negedge clk);
    cmd_valid_i = 1'b0;
    repeat (20) @(negedge clk);
    #1 rst_ni = 1'b0;
    #1;
    chk({busy_o, cal_pulse_o, trig_o, done_o, err_o, overrun_o} == 6'b0, "R10 async reset",
        int'({busy_o, cal_pulse_o, trig_o, done_o, err_o, overrun_o}), 0);
    @(negedge clk);
    rst_ni = 1'b1;
    run(VECS[4], -1);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule